// File: doc/BRIEF.md
# Two-Level Thermal Throttle Controller

This block chooses a throttling response from how far a temperature code is over two programmable limits. Below the lower limit it leaves the core alone. Between the lower and the upper limit it applies a local throttle: it withholds instruction fetch on a programmable share of clock cycles. At or above the upper limit it gives up fetch gating and instead asks the global voltage/frequency supply for its low step.

The two throttles never stack. While the low step is requested, fetch runs on every cycle. To stop the supply request from chattering, leaving the severe response requires the temperature to fall a programmable margin below the upper limit. After every change of the supply request, the request is also held for a fixed settle count. The voltage regulator, the clock generator and the pipeline that consumes the fetch enable are outside the block.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: While reset is held and right after it, `mode` is 00, `vf_low` is 0 and `fetch_en` is 1.
- R2: When not in the severe mode, a temperature below `mild_thr` gives `mode` 00 one clock later, and `fetch_en` stays 1 on every cycle.
- R3: A temperature at or above `mild_thr` and below `severe_thr` gives `mode` 01 (fetch gating) one clock later.
- R4: In mode 01, any 256 consecutive cycles counted from entry into the mode contain exactly `duty` cycles with `fetch_en` at 0. A duty of 0 never blocks fetch, and a duty of 255 blocks all cycles but one.
- R5: In mode 01 the blocked cycles are spread evenly. With `duty` at or below 128, two consecutive cycles are never both blocked.
- R6: A temperature at or above `severe_thr` gives `mode` 10 with `vf_low` at 1 one clock later, provided the settle count has elapsed. `vf_low` is 1 exactly when `mode` is 10.
- R7: In mode 10, `fetch_en` is 1 on every cycle.
- R8: Mode 10 is left only when `temp + hyst < severe_thr`. On leaving, the block goes to mode 01 if the temperature is at or above `mild_thr`, and to mode 00 otherwise.
- R9: After `vf_low` changes, it holds its value for the following SETTLE_CYC clock edges and can change at the edge after those at the earliest. While a rise is blocked this way, the block stays in mode 01.
- R10: The mode code 11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp | input | TEMP_W | Current temperature code |
| mild_thr | input | TEMP_W | Lower limit that starts fetch gating |
| severe_thr | input | TEMP_W | Upper limit that forces the low voltage/frequency step |
| hyst | input | TEMP_W | Margin below `severe_thr` needed to leave the severe mode |
| duty | input | DUTY_W | Number of blocked fetch cycles per 2^DUTY_W cycles |
| fetch_en | output | 1 | Fetch permitted in this cycle |
| vf_low | output | 1 | Request for the low voltage/frequency step |
| mode | output | 2 | Response code: 00 none, 01 fetch gating, 10 low step |

## Verification
The bench builds the block with TEMP_W 10, DUTY_W 8 and SETTLE_CYC reduced to 12. The short settle count lets a blocked re-escalation be timed edge by edge: the bench can check that the request changes on exactly the thirteenth edge after the previous change. With an 8-bit duty, whole 256-cycle windows fit in a short run, so the bench counts the blocked cycles exactly at duties 0, 1, 64, 128, 200 and 255. Hysteresis is probed at the boundary temperatures one unit on either side of `severe_thr - hyst`.

// File: rtl/thr_pkg.sv
package thr_pkg;
  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_GATE = 2'b01,
    MODE_LOW  = 2'b10
  } thr_mode_e;
endpackage

// File: rtl/thr_mode_fsm.sv
module thr_mode_fsm
  import thr_pkg::*;
#(
  parameter int TEMP_W     = 10,
  parameter int SETTLE_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp,
  input  logic [TEMP_W-1:0] mild_thr,
  input  logic [TEMP_W-1:0] severe_thr,
  input  logic [TEMP_W-1:0] hyst,
  output thr_mode_e         mode_q
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC);

  thr_mode_e        mode_d;
  logic [CNT_W-1:0] settle_q, settle_d;
  logic             mild_hit, severe_hit, exit_ok, settled, vf_flip;

  always_comb begin
    mild_hit   = (temp >= mild_thr);
    severe_hit = (temp >= severe_thr);
    exit_ok    = (({1'b0, temp} + {1'b0, hyst}) < {1'b0, severe_thr});
    settled    = (settle_q == '0);
  end

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      MODE_LOW: begin
        if (exit_ok && settled) mode_d = mild_hit ? MODE_GATE : MODE_NONE;
      end
      default: begin
        if (severe_hit && settled) mode_d = MODE_LOW;
        else                       mode_d = mild_hit ? MODE_GATE : MODE_NONE;
      end
    endcase
  end

  always_comb begin
    vf_flip  = ((mode_d == MODE_LOW) != (mode_q == MODE_LOW));
    settle_d = settle_q;
    if (vf_flip)       settle_d = SETTLE_LD;
    else if (!settled) settle_d = settle_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_NONE;
      settle_q <= '0;
    end else begin
      mode_q   <= mode_d;
      settle_q <= settle_d;
    end
  end
endmodule

// File: rtl/thr_fetch_gate.sv
module thr_fetch_gate #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_active,
  input  logic [DUTY_W-1:0] duty,
  output logic              fetch_en
);
  logic [DUTY_W-1:0] acc_q, acc_d;
  logic [DUTY_W:0]   sum;

  always_comb begin
    sum      = {1'b0, acc_q} + {1'b0, duty};
    fetch_en = !(gate_active && sum[DUTY_W]);
    acc_d    = gate_active ? sum[DUTY_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl
  import thr_pkg::*;
#(
  parameter int TEMP_W     = 10,
  parameter int DUTY_W     = 8,
  parameter int SETTLE_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp,
  input  logic [TEMP_W-1:0] mild_thr,
  input  logic [TEMP_W-1:0] severe_thr,
  input  logic [TEMP_W-1:0] hyst,
  input  logic [DUTY_W-1:0] duty,
  output logic              fetch_en,
  output logic              vf_low,
  output logic [1:0]        mode
);
  thr_mode_e mode_q;

  thr_mode_fsm #(.TEMP_W(TEMP_W), .SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .temp(temp), .mild_thr(mild_thr),
    .severe_thr(severe_thr), .hyst(hyst), .mode_q(mode_q)
  );

  thr_fetch_gate #(.DUTY_W(DUTY_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .gate_active(mode_q == MODE_GATE),
    .duty(duty), .fetch_en(fetch_en)
  );

  assign vf_low = (mode_q == MODE_LOW);
  assign mode   = mode_q;
endmodule

// File: rtl/thr_throttle_chk.sv
module thr_throttle_chk #(
  parameter int TEMP_W     = 10,
  parameter int DUTY_W     = 8,
  parameter int SETTLE_CYC = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TEMP_W-1:0] temp,
  input logic [TEMP_W-1:0] severe_thr,
  input logic [TEMP_W-1:0] hyst,
  input logic [DUTY_W-1:0] duty,
  input logic              fetch_en,
  input logic              vf_low,
  input logic [1:0]        mode
);
  localparam int GAP_W = $clog2(SETTLE_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(SETTLE_CYC);
  localparam logic [DUTY_W-1:0] HALF = DUTY_W'(1 << (DUTY_W - 1));

  logic             vf_prev;
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vf_prev <= 1'b0;
      gap     <= GAP_MAX;
    end else begin
      vf_prev <= vf_low;
      if (vf_low != vf_prev)  gap <= '0;
      else if (gap < GAP_MAX) gap <= gap + 1'b1;
    end
  end

  p_legal_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);
  p_vf_tracks_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vf_low == (mode == 2'b10));
  p_no_gate_in_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |-> fetch_en);
  p_no_gate_in_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> fetch_en);
  p_spread_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && !fetch_en && duty <= HALF) |=> (fetch_en || duty > HALF));
  p_hyst_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && ({1'b0, temp} + {1'b0, hyst}) >= {1'b0, severe_thr}) |=> (mode == 2'b10));
  p_settle_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vf_low != vf_prev) |-> (gap >= GAP_MAX));
endmodule

bind thermal_throttle_ctrl thr_throttle_chk #(
  .TEMP_W(TEMP_W), .DUTY_W(DUTY_W), .SETTLE_CYC(SETTLE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .temp(temp), .severe_thr(severe_thr), .hyst(hyst),
  .duty(duty), .fetch_en(fetch_en), .vf_low(vf_low), .mode(mode)
);

// File: tb/thermal_throttle_ctrl_tb_top.sv
`timescale 1ns/1ps
module thermal_throttle_ctrl_tb_top;
  localparam int TW = 10;
  localparam int DW = 8;
  localparam int SC = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [TW-1:0] temp, mild_thr, severe_thr, hyst;
  logic [DW-1:0] duty;
  logic          fetch_en, vf_low;
  logic [1:0]    mode;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  thermal_throttle_ctrl #(.TEMP_W(TW), .DUTY_W(DW), .SETTLE_CYC(SC)) dut_i (
    .clk(clk), .rst_n(rst_n), .temp(temp), .mild_thr(mild_thr),
    .severe_thr(severe_thr), .hyst(hyst), .duty(duty),
    .fetch_en(fetch_en), .vf_low(vf_low), .mode(mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
      if (mode == 2'b11) chk("R10 mode code", mode, 0);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; temp = '0; mild_thr = 10'd300; severe_thr = 10'd500;
    hyst = 10'd20; duty = '0;
    #12;
    chk("R1 mode in reset", mode, 0);
    chk("R1 vf_low in reset", vf_low, 0);
    chk("R1 fetch_en in reset", fetch_en, 1);
    @(negedge clk); rst_n = 1'b1;
    step(1);
    chk("R1 mode after reset", mode, 0);
  endtask

  task automatic t_none;
    int low_seen = 0;
    temp = 10'd100; duty = 8'd200;
    for (int i = 0; i < 20; i++) begin
      step(1);
      if (!fetch_en) low_seen++;
    end
    chk("R2 mode below mild", mode, 0);
    chk("R2 blocked cycles below mild", low_seen, 0);
  endtask

  task automatic t_duty(input int d);
    int lows = 0, run = 0, max_run = 0;
    temp = 10'd100; step(2);
    duty = DW'(d); temp = 10'd350;
    step(1);
    chk("R3 mode in mild band", mode, 1);
    for (int i = 0; i < 256; i++) begin
      if (i > 0) step(1);
      if (!fetch_en) begin lows++; run++; if (run > max_run) max_run = run; end
      else run = 0;
    end
    chk($sformatf("R4 blocked count duty %0d", d), lows, d);
    if (d <= 128) chk($sformatf("R5 longest blocked run duty %0d", d), max_run, d == 0 ? 0 : 1);
  endtask

  task automatic t_severe;
    int low_seen = 0;
    duty = 8'd200; temp = 10'd500;
    step(1);
    chk("R6 mode at severe", mode, 2);
    chk("R6 vf_low at severe", vf_low, 1);
    for (int i = 0; i < 30; i++) begin
      step(1);
      if (!fetch_en) low_seen++;
    end
    chk("R7 blocked cycles in low step", low_seen, 0);
  endtask

  task automatic t_hyst_settle;
    temp = 10'd485; step(SC + 4);
    chk("R8 inside margin stays severe", mode, 2);
    temp = 10'd480; step(3);
    chk("R8 at margin edge stays severe", mode, 2);
    temp = 10'd479; step(1);
    chk("R8 below margin leaves to gating", mode, 1);
    chk("R8 vf_low released", vf_low, 0);
    temp = 10'd600;
    for (int j = 1; j <= SC; j++) begin
      step(1);
      if (vf_low != 1'b0 || mode != 2'b01) chk($sformatf("R9 held at edge %0d", j), {vf_low, mode}, 1);
    end
    chk("R9 held through settle", vf_low, 0);
    chk("R9 gating while blocked", mode, 1);
    step(1);
    chk("R9 rises after settle", vf_low, 1);
  endtask

  task automatic t_low_to_none;
    step(SC + 2);
    temp = 10'd100; step(1);
    chk("R8 severe straight to none", mode, 0);
    chk("R2 fetch on after exit", fetch_en, 1);
  endtask

  initial begin
    t_reset();
    t_none();
    t_duty(0);
    t_duty(1);
    t_duty(64);
    t_duty(128);
    t_duty(200);
    t_duty(255);
    t_severe();
    t_hyst_settle();
    t_low_to_none();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule